// File: doc/BRIEF.md
# Dual-Lane Serial Byte Shifter

This block is a byte-at-a-time serial master. The host offers a byte, a lane mode and a target index, then pulses `start`. The byte goes out most significant bit first. In single-lane mode the byte takes eight serial clock pulses, with one bit per pulse on `mosi`. In dual-lane mode it takes four pulses and carries two bits per pulse. The upper bit of each pair goes on `mosi`. The lower bit goes on `lane2_n`, a pin that otherwise acts as an active-low select and therefore rests high.

Data lines change only while `sclk` is low, and the target samples on the rising edge. The block samples `miso` at each rising edge of its own clock into a receive shifter. When the byte ends, the shifter contents appear on `rx_byte` together with a one-cycle `done`.

Targets 0 and 1 share the select pin `sel_a_n`. Targets 2 and 3 use `sel_b_n`. A select stays low across several bytes. It is released only by `end_cmd`, which raises both select pins so that every command ends with all targets deselected. The half period of `sclk` is set by `half_div`.

Top module: `dual_lane_spi_master`

## Requirements
- R1: In single-lane mode (`dual`=0) a byte gives exactly 8 rising `sclk` edges, and `mosi` at the k-th rising edge (k=0..7) equals `tx_byte[7-k]`.
- R2: In dual-lane mode (`dual`=1) a byte gives exactly 4 rising `sclk` edges. At the k-th edge (k=0..3), `mosi` equals bit 7-2k and `lane2_n` equals bit 6-2k of `tx_byte`.
- R3: `sclk` is low while idle, and `mosi` and `lane2_n` do not change while `sclk` is high.
- R4: Each `sclk` half period lasts `half_div`+1 clock cycles. `busy` is high for exactly slots×2×(`half_div`+1) cycles per byte, where slots is 8 in single-lane mode and 4 in dual-lane mode.
- R5: On `start`, `dev_sel` values 0 and 1 drive `sel_a_n` low and values 2 and 3 drive `sel_b_n` low. At most one select is low at any time, and the select stays low after the byte until `end_cmd`.
- R6: `end_cmd` while idle, without `start`, drives both `sel_a_n` and `sel_b_n` high from the next cycle.
- R7: `rx_byte` holds the `miso` values sampled at the rising edges, first sample in the highest used bit. In single-lane mode all 8 bits are used. In dual-lane mode the 4 samples fill bits 3:0 and bits 7:4 read 0.
- R8: `done` is a one-cycle pulse in the cycle after the final falling `sclk` edge. During that pulse `busy` is low, `sclk` is low and `rx_byte` is already updated.
- R9: `lane2_n` is high whenever the block is idle and throughout single-lane transfers.
- R10: `start` while `busy` is ignored, so the byte in flight is sent unchanged.
- R11: After reset `sclk`=0, `busy`=0, `done`=0, `rx_byte`=0, and `sel_a_n`, `sel_b_n` and `lane2_n` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a byte (taken only while idle) |
| tx_byte | input | 8 | Byte to send |
| dual | input | 1 | 1 = two bits per pulse, 0 = one bit per pulse |
| dev_sel | input | 2 | Target index; 0/1 use `sel_a_n`, 2/3 use `sel_b_n` |
| end_cmd | input | 1 | Release both selects (taken while idle) |
| half_div | input | DIVW | Half period of `sclk` minus one, in clock cycles |
| miso | input | 1 | Serial data from target |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Primary data out |
| lane2_n | output | 1 | Second data lane in dual-lane mode, otherwise an inactive-high select |
| sel_a_n | output | 1 | Select shared by targets 0 and 1, active low |
| sel_b_n | output | 1 | Select for targets 2 and 3, active low |
| busy | output | 1 | A byte is being shifted |
| done | output | 1 | One-cycle pulse at byte completion |
| rx_byte | output | 8 | Captured receive byte |

## Verification
The assertions assume that the host raises `end_cmd` only while the block is idle and never in the same cycle as `start`. The stimulus follows this: each command closes only after `done`, and `end_cmd` is given its own cycle. The checks also rely on `miso` moving only after a falling `sclk`. The bench's target model shifts `miso` one half-cycle after each observed falling edge, so the value sampled at the next rising edge is always settled.

// File: rtl/dual_lane_spi_master.sv
module dual_lane_spi_master #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [7:0]      tx_byte,
  input  logic            dual,
  input  logic [1:0]      dev_sel,
  input  logic            end_cmd,
  input  logic [DIVW-1:0] half_div,
  input  logic            miso,
  output logic            sclk,
  output logic            mosi,
  output logic            lane2_n,
  output logic            sel_a_n,
  output logic            sel_b_n,
  output logic            busy,
  output logic            done,
  output logic [7:0]      rx_byte
);
  localparam logic [2:0] LAST_ONE = 3'd7;
  localparam logic [2:0] LAST_TWO = 3'd3;

  logic [DIVW-1:0] cnt;
  logic [2:0]      slot;
  logic [7:0]      sh;
  logic [7:0]      rx;
  logic            mode;

  wire tick = (cnt == half_div);
  wire last = (slot == (mode ? LAST_TWO : LAST_ONE));

  assign mosi    = busy & sh[7];
  assign lane2_n = (busy & mode) ? sh[6] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      sclk    <= 1'b0;
      cnt     <= '0;
      slot    <= '0;
      sh      <= '0;
      rx      <= '0;
      mode    <= 1'b0;
      rx_byte <= '0;
      sel_a_n <= 1'b1;
      sel_b_n <= 1'b1;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          sh      <= tx_byte;
          rx      <= '0;
          mode    <= dual;
          cnt     <= '0;
          slot    <= '0;
          sclk    <= 1'b0;
          sel_a_n <= dev_sel[1];
          sel_b_n <= ~dev_sel[1];
        end else if (end_cmd) begin
          sel_a_n <= 1'b1;
          sel_b_n <= 1'b1;
        end
      end else if (tick) begin
        cnt  <= '0;
        sclk <= ~sclk;
        if (!sclk) begin
          rx <= {rx[6:0], miso};
        end else if (last) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          rx_byte <= rx;
        end else begin
          slot <= slot + 3'd1;
          sh   <= mode ? {sh[5:0], 2'b00} : {sh[6:0], 1'b0};
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

module spi_master_checks (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic end_cmd,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic mosi,
  input logic lane2_n,
  input logic sel_a_n,
  input logic sel_b_n
);
  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> ($stable(mosi) && $stable(lane2_n)));

  assert_idle_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !sclk);

  assert_one_select_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a_n || sel_b_n));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (end_cmd && !busy && !start) |=> (sel_a_n && sel_b_n));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !sclk));

  assert_lane_rest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> lane2_n);
endmodule

bind dual_lane_spi_master spi_master_checks u_chk (.*);

// File: tb/sim_dual_lane_spi_master.sv
`timescale 1ns/1ps
module sim_dual_lane_spi_master;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, start = 0, dual = 0, end_cmd = 0, miso = 0;
  logic [7:0] tx_byte = 0, half_div = 0;
  logic [1:0] dev_sel = 0;
  logic sclk, mosi, lane2_n, sel_a_n, sel_b_n, busy, done;
  logic [7:0] rx_byte;

  int checks = 0, fails = 0, cyc = 0;

  dual_lane_spi_master #(.DIVW(8)) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  logic prev_sclk = 0;
  int npulse = 0;
  logic [7:0] mb = 0, lb = 0, sbyte = 0;

  always @(negedge clk) begin
    if (sclk && !prev_sclk) begin
      mb = {mb[6:0], mosi};
      lb = {lb[6:0], lane2_n};
      npulse++;
    end
    if (!sclk && prev_sclk) begin
      sbyte = {sbyte[6:0], 1'b0};
      miso = sbyte[7];
    end
    prev_sclk = sclk;
  end

  function automatic logic [7:0] exp_rx(input logic [7:0] s, input bit d);
    return d ? {4'b0, s[7:4]} : s;
  endfunction

  task automatic xfer(input logic [7:0] tx, input bit d, input logic [1:0] s,
                      input logic [7:0] dv, input logic [7:0] sb, input bit hit_busy);
    int bc;
    logic [7:0] got;
    @(negedge clk);
    tx_byte = tx; dual = d; dev_sel = s; half_div = dv;
    sbyte = sb; miso = sb[7]; npulse = 0; mb = 0; lb = 0; start = 1;
    @(negedge clk);
    bc = 0;
    while (!done) begin
      if (busy) bc++;
      if (hit_busy && bc == 2) begin start = 1; tx_byte = ~tx; end
      else start = 0;
      @(negedge clk);
    end
    start = 0;
    got = d ? {mb[3], lb[3], mb[2], lb[2], mb[1], lb[1], mb[0], lb[0]} : mb;
    if (d) begin
      check("R2 pulses", npulse, 4);
      check(hit_busy ? "R10 byte kept" : "R2 dual data", got, tx);
    end else begin
      check("R1 pulses", npulse, 8);
      check(hit_busy ? "R10 byte kept" : "R1 single data", got, tx);
      check("R9 lane2 rest in single", lb, 8'hFF);
    end
    check("R4 busy length", bc, (d ? 4 : 8) * 2 * (int'(dv) + 1));
    check("R7 rx byte", rx_byte, exp_rx(sb, d));
    check("R8 busy low at done", busy, 0);
    check("R5 select a", sel_a_n, s[1]);
    check("R5 select b", sel_b_n, !s[1]);
    @(negedge clk);
    check("R8 single pulse", done, 0);
    check("R3 sclk idle low", sclk, 0);
    check("R9 lane2 idle", lane2_n, 1);
  endtask

  task automatic end_command();
    @(negedge clk); end_cmd = 1;
    @(negedge clk); end_cmd = 0;
    check("R6 sel a released", sel_a_n, 1);
    check("R6 sel b released", sel_b_n, 1);
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    check("R11 sclk", sclk, 0);
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 rx", rx_byte, 0);
    check("R11 sel a", sel_a_n, 1);
    check("R11 sel b", sel_b_n, 1);
    check("R11 lane2", lane2_n, 1);
    rst_n = 1;
    xfer(8'hA5, 0, 2'd0, 8'd0, 8'h3C, 0);
    xfer(8'h5A, 0, 2'd0, 8'd1, 8'hC3, 0);
    end_command();
    xfer(8'hC9, 1, 2'd1, 8'd1, 8'hB7, 0);
    end_command();
    xfer(8'hFF, 0, 2'd2, 8'd2, 8'h00, 0);
    end_command();
    xfer(8'h00, 1, 2'd3, 8'd0, 8'hFF, 0);
    end_command();
    xfer(8'h96, 1, 2'd1, 8'd1, 8'h81, 1);
    xfer(8'h3E, 0, 2'd1, 8'd0, 8'h7E, 1);
    end_command();
    for (int i = 0; i < 40; i++) begin
      xfer(8'($urandom), 1'($urandom), 2'($urandom), 8'($urandom % 4), 8'($urandom), 0);
      if ($urandom % 2) end_command();
    end
    end_command();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule